// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block owns the program counter of a 32-bit processor whose instructions are all one aligned 32-bit word. Each cycle it takes the decoded control-flow class of the current instruction, together with the 16-bit branch displacement, the 26-bit jump target field, the two register values to compare and a full register value for indirect jumps. From these it forms the address of the next fetch. It also offers the return address that a jump-and-link writes to the link register.

Branches are relative to the PC and measured in words from the following instruction. A direct jump stays inside the current 256 MB region, because it keeps the top four PC bits. An indirect jump through a register can reach any aligned address. The PC moves only in cycles where the advance strobe is high, so a stalled pipeline holds it in place. A synchronous reset loads a parameterised start address.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the PC is loaded with `START_ADDR` with bits 1..0 forced to zero.
- R2: At an edge where `adv_i` is low and `rst` is low, the PC keeps its value whatever the other inputs are.
- R3: Flow code 0 (sequential) moves the PC to PC+4. Unused codes 6 and 7 behave the same way. The PC wraps modulo 2^32.
- R4: Flow code 1 (branch-if-equal) moves the PC to PC + 4 + 4 × offset when `opa_i == opb_i`, and to PC+4 otherwise.
- R5: Flow code 2 (branch-if-not-equal) moves the PC to PC + 4 + 4 × offset when `opa_i != opb_i`, and to PC+4 when they are equal.
- R6: The branch offset is a two's-complement word count, sign-extended from bit 15, so 16'hFFFE lands two words before PC+4.
- R7: Flow code 3 (direct jump) loads PC bits 31..28 from the current PC, bits 27..2 from `target_i` and bits 1..0 with zero.
- R8: Flow code 4 (jump-and-link) moves the PC exactly as code 3 does. In that cycle `link_valid_o` is high and `link_addr_o` equals the current PC+4. For every other code, `link_valid_o` is low.
- R9: Flow code 5 (register jump) loads `jreg_i` bits 31..2 into the PC and clears bits 1..0, so it can leave the current region.
- R10: PC bits 1..0 are zero in every cycle after reset.
- R11: `next_pc_o` always shows the value that the PC takes at the next advancing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_i | input | 1 | Advance strobe; the PC updates only when this is high |
| flow_i | input | 3 | Control-flow class: 0 seq, 1 beq, 2 bne, 3 jump, 4 jump-and-link, 5 register jump |
| offset_i | input | 16 | Signed branch displacement in words |
| target_i | input | 26 | Word target field for direct jumps |
| opa_i | input | 32 | First compare operand |
| opb_i | input | 32 | Second compare operand |
| jreg_i | input | 32 | Register value for indirect jumps |
| pc_o | output | 32 | Current program counter |
| next_pc_o | output | 32 | Address the PC takes on the next advance |
| link_addr_o | output | 32 | Return address (PC+4) |
| link_valid_o | output | 1 | High when the current class is jump-and-link |

## Verification
The two functions that can fall in one cycle are the jump-and-link redirect and the production of the return address. Both come from the same PC value, but they become visible at different times. The bench issues jump-and-link from several regions and checks `link_addr_o` combinationally in the issuing cycle, before the edge. It then checks the redirected PC after the edge, so a design that takes the link from the new PC, or that skips the redirect, fails one of the two comparisons. Branch-if-not-equal with equal operands is also issued on an address that would wrap, so that the not-taken path and the sequential increment are judged against each other.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int unsigned XLEN     = 32;
    localparam int unsigned OFFW     = 16;
    localparam int unsigned TGTW     = 26;
    localparam int unsigned ALIGNW   = 2;
    localparam int unsigned REGIONW  = XLEN - TGTW - ALIGNW;
    localparam int unsigned SEXTW    = XLEN - OFFW - ALIGNW;
    localparam logic [XLEN-1:0] WORD_BYTES = XLEN'(4);

    typedef logic [XLEN-1:0] addr_t;

    typedef enum logic [2:0] {
        FLOW_SEQ  = 3'd0,
        FLOW_BEQ  = 3'd1,
        FLOW_BNE  = 3'd2,
        FLOW_JMP  = 3'd3,
        FLOW_JAL  = 3'd4,
        FLOW_JREG = 3'd5
    } flow_e;

    typedef struct packed {
        addr_t fall;
        addr_t branch;
        addr_t region;
        addr_t indirect;
    } cand_t;

    function automatic addr_t word_align(input addr_t a);
        return {a[XLEN-1:ALIGNW], {ALIGNW{1'b0}}};
    endfunction

    function automatic addr_t branch_disp(input logic [OFFW-1:0] off);
        return {{SEXTW{off[OFFW-1]}}, off, {ALIGNW{1'b0}}};
    endfunction

    function automatic addr_t region_target(input addr_t pc, input logic [TGTW-1:0] tgt);
        return {pc[XLEN-1 -: REGIONW], tgt, {ALIGNW{1'b0}}};
    endfunction

    function automatic flow_e decode_flow(input logic [2:0] code);
        flow_e f;
        case (code)
            3'd1:    f = FLOW_BEQ;
            3'd2:    f = FLOW_BNE;
            3'd3:    f = FLOW_JMP;
            3'd4:    f = FLOW_JAL;
            3'd5:    f = FLOW_JREG;
            default: f = FLOW_SEQ;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/npc_cmp.sv
module npc_cmp
    import npc_pkg::*;
(
    input  flow_e            flow,
    input  logic [XLEN-1:0]  opa,
    input  logic [XLEN-1:0]  opb,
    output logic             taken
);
    logic same;

    assign same = (opa == opb);

    always_comb begin
        case (flow)
            FLOW_BEQ: taken = same;
            FLOW_BNE: taken = !same;
            default:  taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/npc_cand.sv
module npc_cand
    import npc_pkg::*;
(
    input  addr_t            pc,
    input  logic [OFFW-1:0]  offset,
    input  logic [TGTW-1:0]  target,
    input  addr_t            jreg,
    output cand_t            cand
);
    always_comb begin
        cand.fall     = pc + WORD_BYTES;
        cand.branch   = cand.fall + branch_disp(offset);
        cand.region   = region_target(pc, target);
        cand.indirect = word_align(jreg);
    end
endmodule

// File: rtl/npc_sel.sv
module npc_sel
    import npc_pkg::*;
(
    input  flow_e  flow,
    input  logic   taken,
    input  cand_t  cand,
    output addr_t  next_pc
);
    always_comb begin
        case (flow)
            FLOW_BEQ,
            FLOW_BNE:  next_pc = taken ? cand.branch : cand.fall;
            FLOW_JMP,
            FLOW_JAL:  next_pc = cand.region;
            FLOW_JREG: next_pc = cand.indirect;
            default:   next_pc = cand.fall;
        endcase
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter logic [31:0] START_ADDR = 32'h0000_1000
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv_i,
    input  logic [2:0]   flow_i,
    input  logic [15:0]  offset_i,
    input  logic [25:0]  target_i,
    input  logic [31:0]  opa_i,
    input  logic [31:0]  opb_i,
    input  logic [31:0]  jreg_i,
    output logic [31:0]  pc_o,
    output logic [31:0]  next_pc_o,
    output logic [31:0]  link_addr_o,
    output logic         link_valid_o
);
    localparam addr_t RESET_PC = word_align(START_ADDR);

    flow_e  flow;
    logic   taken;
    cand_t  cand;
    addr_t  pc_q;
    addr_t  nxt;

    assign flow = decode_flow(flow_i);

    npc_cmp u_cmp (
        .flow  (flow),
        .opa   (opa_i),
        .opb   (opb_i),
        .taken (taken)
    );

    npc_cand u_cand (
        .pc     (pc_q),
        .offset (offset_i),
        .target (target_i),
        .jreg   (jreg_i),
        .cand   (cand)
    );

    npc_sel u_sel (
        .flow    (flow),
        .taken   (taken),
        .cand    (cand),
        .next_pc (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst)        pc_q <= RESET_PC;
        else if (adv_i) pc_q <= nxt;
    end

    assign pc_o         = pc_q;
    assign next_pc_o    = nxt;
    assign link_addr_o  = cand.fall;
    assign link_valid_o = (flow == FLOW_JAL);
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk (
    input logic         clk,
    input logic         rst,
    input logic         adv_i,
    input logic [2:0]   flow_i,
    input logic [31:0]  opa_i,
    input logic [31:0]  opb_i,
    input logic [31:0]  jreg_i,
    input logic [31:0]  pc_o,
    input logic [31:0]  next_pc_o,
    input logic [31:0]  link_addr_o,
    input logic         link_valid_o
);
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !adv_i |=> $stable(pc_o)) else $error("hold"); // R2

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (adv_i && flow_i == 3'd0) |=> pc_o == $past(pc_o) + 32'd4) else $error("seq"); // R3

    AST_BNE_FALL: assert property (@(posedge clk) disable iff (rst)
        (adv_i && flow_i == 3'd2 && opa_i == opb_i) |=> pc_o == $past(pc_o) + 32'd4) else $error("bne"); // R5

    AST_JMP_REGION: assert property (@(posedge clk) disable iff (rst)
        (adv_i && (flow_i == 3'd3 || flow_i == 3'd4)) |=> pc_o[31:28] == $past(pc_o[31:28])) else $error("region"); // R7

    AST_LINK_ADDR: assert property (@(posedge clk) disable iff (rst)
        link_valid_o |-> link_addr_o == pc_o + 32'd4) else $error("link"); // R8

    AST_JREG_LOAD: assert property (@(posedge clk) disable iff (rst)
        (adv_i && flow_i == 3'd5) |=> pc_o[31:2] == $past(jreg_i[31:2])) else $error("jreg"); // R9

    AST_PC_ALIGN: assert property (@(posedge clk) disable iff (rst)
        pc_o[1:0] == 2'b00) else $error("align"); // R10

    AST_NEXT_MATCH: assert property (@(posedge clk) disable iff (rst)
        adv_i |=> pc_o == $past(next_pc_o)) else $error("next"); // R11
endmodule

bind npc_unit npc_unit_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .adv_i        (adv_i),
    .flow_i       (flow_i),
    .opa_i        (opa_i),
    .opb_i        (opb_i),
    .jreg_i       (jreg_i),
    .pc_o         (pc_o),
    .next_pc_o    (next_pc_o),
    .link_addr_o  (link_addr_o),
    .link_valid_o (link_valid_o)
);

// File: tb/npc_unit_tb_top.sv
module npc_unit_tb_top;
    localparam logic [31:0] START = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        adv_i = 1'b0;
    logic [2:0]  flow_i = 3'd0;
    logic [15:0] offset_i = '0;
    logic [25:0] target_i = '0;
    logic [31:0] opa_i = '0, opb_i = '0, jreg_i = '0;
    logic [31:0] pc_o, next_pc_o, link_addr_o;
    logic        link_valid_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] model_pc;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          done = 1'b0;

    always #10 clk = ~clk;

    npc_unit #(.START_ADDR(START)) dut_i (
        .clk(clk), .rst(rst), .adv_i(adv_i), .flow_i(flow_i),
        .offset_i(offset_i), .target_i(target_i), .opa_i(opa_i),
        .opb_i(opb_i), .jreg_i(jreg_i), .pc_o(pc_o),
        .next_pc_o(next_pc_o), .link_addr_o(link_addr_o),
        .link_valid_o(link_valid_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Driver: applies one instruction class at a negedge and queues the expected PC.
    task automatic step(input string tag, input logic adv, input logic [2:0] fl,
                        input logic [15:0] off, input logic [25:0] tgt,
                        input logic [31:0] a, input logic [31:0] b, input logic [31:0] r);
        logic [31:0] fall, disp, nxt;
        @(negedge clk);
        adv_i = adv; flow_i = fl; offset_i = off; target_i = tgt;
        opa_i = a; opb_i = b; jreg_i = r;
        fall = model_pc + 32'd4;
        disp = {{14{off[15]}}, off, 2'b00};
        case (fl)
            3'd1: nxt = (a == b) ? fall + disp : fall;
            3'd2: nxt = (a != b) ? fall + disp : fall;
            3'd3, 3'd4: nxt = {model_pc[31:28], tgt, 2'b00};
            3'd5: nxt = {r[31:2], 2'b00};
            default: nxt = fall;
        endcase
        #1;
        check({tag, " R11 next"}, next_pc_o, nxt);
        check({tag, " R8 link_valid"}, {31'd0, link_valid_o}, {31'd0, fl == 3'd4});
        if (fl == 3'd4) check({tag, " R8 link_addr"}, link_addr_o, fall);
        if (adv) model_pc = nxt;
        exp_q.push_back(model_pc);
        tag_q.push_back(tag);
    endtask

    // Monitor: compares the PC shortly after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) check(tag_q.pop_front(), pc_o, exp_q.pop_front());
        end
    end

    initial begin
        #4000000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_pc = START;
        check("R1 reset pc", pc_o, START);
        step("R3 seq",          1, 3'd0, 16'h0,    26'h0, 0, 0, 0);
        step("R3 seq again",    1, 3'd0, 16'h0,    26'h0, 0, 0, 0);
        step("R2 hold",         0, 3'd5, 16'h0,    26'h0, 0, 0, 32'hDEAD_BEE0);
        step("R2 hold beq",     0, 3'd1, 16'h0040, 26'h0, 5, 5, 0);
        step("R4 beq taken",    1, 3'd1, 16'h0010, 26'h0, 32'h7, 32'h7, 0);
        step("R4 beq not",      1, 3'd1, 16'h0010, 26'h0, 32'h7, 32'h8, 0);
        step("R5 bne taken",    1, 3'd2, 16'h0003, 26'h0, 32'h1, 32'h2, 0);
        step("R5 bne equal",    1, 3'd2, 16'h0003, 26'h0, 32'h9, 32'h9, 0);
        step("R6 back beq",     1, 3'd1, 16'hFFFE, 26'h0, 0, 0, 0);
        step("R6 back bne",     1, 3'd2, 16'h8000, 26'h0, 1, 0, 0);
        step("R9 jreg unalign", 1, 3'd5, 16'h0,    26'h0, 0, 0, 32'hA000_0013);
        step("R7 jmp region",   1, 3'd3, 16'h0,    26'h3FF_FFFF, 0, 0, 0);
        step("R8 jal",          1, 3'd4, 16'h0,    26'h000_0040, 0, 0, 0);
        step("R9 jreg far",     1, 3'd5, 16'h0,    26'h0, 0, 0, 32'h5123_4568);
        step("R8 jal region5",  1, 3'd4, 16'h0,    26'h123_4567, 0, 0, 0);
        step("R3 code6",        1, 3'd6, 16'h0100, 26'h1, 0, 0, 32'h8);
        step("R3 code7",        1, 3'd7, 16'h0100, 26'h1, 0, 0, 32'h8);
        step("R9 jreg top",     1, 3'd5, 16'h0,    26'h0, 0, 0, 32'hFFFF_FFFE);
        step("R5 bne eq wrap",  1, 3'd2, 16'h0004, 26'h0, 3, 3, 0);
        step("R10 seq",         1, 3'd0, 16'h0,    26'h0, 0, 0, 0);
        step("R2 hold jal",     0, 3'd4, 16'h0,    26'h2A,0, 0, 0);
        step("R4 beq max fwd",  1, 3'd1, 16'h7FFF, 26'h0, 0, 0, 0);
        @(negedge clk);
        adv_i = 1'b0;
        repeat (3) @(posedge clk);
        #6;
        check("R10 align", {30'd0, pc_o[1:0]}, 32'd0);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #5;
        check("R1 reset again", pc_o, START);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule